// File: doc/BRIEF.md
# Dual-Rail Logic Evaluator with Completion Detection

This block evaluates a small bitwise datapath in which every logical bit travels on two wires, a high rail and a low rail. The pair 00 is a spacer meaning "no data yet", 01 carries logic 0, 10 carries logic 1, and 11 is illegal. Two operands of `W` bits enter in this code. The block returns their bitwise AND, their bitwise OR and the complement of the first operand, all in the same two-rail code. Because the code itself shows whether a bit has arrived, no separate valid strobe is needed. A completion flag is derived from the result wires alone.

Operands alternate between data waves and spacer waves. A clocked wrapper samples the operand wires on every rising edge, evaluates the rail equations and registers the results together with a completion flag and an error flag. The completion flag uses hysteresis. It rises only once every result bit holds a legal value, and it falls only once every result bit has gone back to spacer. Mixed states leave it unchanged. Any operand bit carrying 11 raises the error flag and is never decoded as a value: that bit position is handled as a spacer.

Top module: `dual_rail_eval`

## Requirements
- R1: Operand wires are sampled on a rising clock edge, and the results, `done` and `err` for that sample appear after the next rising edge, a latency of two edges.
- R2: For each bit, the AND result high rail is the AND of the two operand high rails and its low rail is the OR of the two operand low rails (code 00 spacer, 01 logic 0, 10 logic 1).
- R3: For each bit, the OR result high rail is the OR of the two operand high rails and its low rail is the AND of the two operand low rails.
- R4: For each bit, the complement result swaps the rails of operand A: its high rail is A's low rail and its low rail is A's high rail.
- R5: No result bit ever shows the code 11 (both rails high).
- R6: An operand bit holding 11 is treated as the spacer 00 at that bit position for every result that uses it, so it is never decoded as 0 or 1.
- R7: `done` goes high on the edge where all 3*W result bits hold 01 or 10.
- R8: Once high, `done` stays high while some result bits are spacer. It goes low only on the edge where all 3*W result bits are 00. While low, it stays low through mixed states.
- R9: `err` is high in the cycle whose results come from a sample in which any bit of either operand held 11, or when any result bit would hold 11.
- R10: While `rst_n` is low, all result rails, `done` and `err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_hi | input | W | Operand A high rails |
| a_lo | input | W | Operand A low rails |
| b_hi | input | W | Operand B high rails |
| b_lo | input | W | Operand B low rails |
| and_hi | output | W | Bitwise AND result, high rails |
| and_lo | output | W | Bitwise AND result, low rails |
| or_hi | output | W | Bitwise OR result, high rails |
| or_lo | output | W | Bitwise OR result, low rails |
| not_hi | output | W | Complement of A, high rails |
| not_lo | output | W | Complement of A, low rails |
| done | output | 1 | Completion flag with hysteresis |
| err | output | 1 | Illegal code seen in the sampled operands or the results |

## Verification
The hardest behaviour to reach is the hysteresis of `done` across partial waves. Some states leave `done` unchanged: a result set that is only partly valid, for example an AND that resolves to 0 early because one operand is 0 while the other is still spacer. Reaching these states needs operand waves that leave single bits at spacer or at 11. The stimulus builds them in two ways. Directed sequences move from full data through partial data to spacer and back. A random run then draws each operand bit independently from all four codes, while the bench's behavioural model tracks the expected flag state on every cycle.

// File: rtl/dr_pkg.sv
package dr_pkg;

    // Two-rail code of one logical bit: {high rail, low rail}
    typedef enum logic [1:0] {
        DR_SPACER = 2'b00,
        DR_ZERO   = 2'b01,
        DR_ONE    = 2'b10,
        DR_ILLEGAL = 2'b11
    } dr_code_e;

    function automatic logic dr_is_data(input logic hi, input logic lo);
        dr_code_e c;
        c = dr_code_e'({hi, lo});
        return (c == DR_ZERO) || (c == DR_ONE);
    endfunction

    function automatic logic dr_is_spacer(input logic hi, input logic lo);
        return dr_code_e'({hi, lo}) == DR_SPACER;
    endfunction

    function automatic logic dr_is_illegal(input logic hi, input logic lo);
        return dr_code_e'({hi, lo}) == DR_ILLEGAL;
    endfunction

endpackage

// File: rtl/dr_sanitize.sv
// Replaces each illegal two-rail bit by the spacer code and reports it (R6, R9).
module dr_sanitize
    import dr_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] raw_hi,
    input  logic [W-1:0] raw_lo,
    output logic [W-1:0] clean_hi,
    output logic [W-1:0] clean_lo,
    output logic         any_illegal
);

    logic [W-1:0] bad_bit;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_comb begin
            bad_bit[i]  = dr_is_illegal(raw_hi[i], raw_lo[i]);
            clean_hi[i] = raw_hi[i] & ~bad_bit[i];
            clean_lo[i] = raw_lo[i] & ~bad_bit[i];
        end
    end

    assign any_illegal = |bad_bit;

endmodule

// File: rtl/dr_gate_bank.sv
// Bitwise two-rail AND, OR and complement (R2, R3, R4).
module dr_gate_bank #(
    parameter int W = 4
) (
    input  logic [W-1:0] a_hi,
    input  logic [W-1:0] a_lo,
    input  logic [W-1:0] b_hi,
    input  logic [W-1:0] b_lo,
    output logic [W-1:0] and_hi,
    output logic [W-1:0] and_lo,
    output logic [W-1:0] or_hi,
    output logic [W-1:0] or_lo,
    output logic [W-1:0] not_hi,
    output logic [W-1:0] not_lo
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_comb begin
            // R2: true rail needs both trues, false rail needs either false
            and_hi[i] = a_hi[i] & b_hi[i];
            and_lo[i] = a_lo[i] | b_lo[i];
            // R3: dual of the AND
            or_hi[i]  = a_hi[i] | b_hi[i];
            or_lo[i]  = a_lo[i] & b_lo[i];
            // R4: complement is a rail swap
            not_hi[i] = a_lo[i];
            not_lo[i] = a_hi[i];
        end
    end

endmodule

// File: rtl/dr_completion.sv
// Classifies N two-rail bits: all data, all spacer, any illegal (R5, R7, R8).
module dr_completion
    import dr_pkg::*;
#(
    parameter int N = 12
) (
    input  logic [N-1:0] hi,
    input  logic [N-1:0] lo,
    output logic         all_data,
    output logic         all_spacer,
    output logic         any_illegal
);

    logic [N-1:0] data_bit;
    logic [N-1:0] spacer_bit;
    logic [N-1:0] bad_bit;

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_comb begin
            data_bit[i]   = dr_is_data(hi[i], lo[i]);
            spacer_bit[i] = dr_is_spacer(hi[i], lo[i]);
            bad_bit[i]    = dr_is_illegal(hi[i], lo[i]);
        end
    end

    assign all_data    = &data_bit;
    assign all_spacer  = &spacer_bit;
    assign any_illegal = |bad_bit;

endmodule

// File: rtl/dual_rail_eval.sv
module dual_rail_eval
    import dr_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_hi,
    input  logic [W-1:0] a_lo,
    input  logic [W-1:0] b_hi,
    input  logic [W-1:0] b_lo,
    output logic [W-1:0] and_hi,
    output logic [W-1:0] and_lo,
    output logic [W-1:0] or_hi,
    output logic [W-1:0] or_lo,
    output logic [W-1:0] not_hi,
    output logic [W-1:0] not_lo,
    output logic         done,
    output logic         err
);

    localparam int NRES = 3 * W;

    typedef struct packed {
        // stage 1: sampled, cleaned operands (R1, R6)
        logic [W-1:0] a_hi;
        logic [W-1:0] a_lo;
        logic [W-1:0] b_hi;
        logic [W-1:0] b_lo;
        logic         in_bad;
        // stage 2: registered results and flags
        logic [W-1:0] and_hi;
        logic [W-1:0] and_lo;
        logic [W-1:0] or_hi;
        logic [W-1:0] or_lo;
        logic [W-1:0] not_hi;
        logic [W-1:0] not_lo;
        logic         done;
        logic         err;
    } eval_state_t;

    eval_state_t st_d, st_q;

    logic [W-1:0] ca_hi, ca_lo, cb_hi, cb_lo;
    logic         bad_a, bad_b;
    logic [W-1:0] g_and_hi, g_and_lo, g_or_hi, g_or_lo, g_not_hi, g_not_lo;
    logic         res_all_data, res_all_spacer, res_bad;

    dr_sanitize #(.W(W)) u_clean_a (
        .raw_hi      (a_hi),
        .raw_lo      (a_lo),
        .clean_hi    (ca_hi),
        .clean_lo    (ca_lo),
        .any_illegal (bad_a)
    );

    dr_sanitize #(.W(W)) u_clean_b (
        .raw_hi      (b_hi),
        .raw_lo      (b_lo),
        .clean_hi    (cb_hi),
        .clean_lo    (cb_lo),
        .any_illegal (bad_b)
    );

    dr_gate_bank #(.W(W)) u_gates (
        .a_hi   (st_q.a_hi),
        .a_lo   (st_q.a_lo),
        .b_hi   (st_q.b_hi),
        .b_lo   (st_q.b_lo),
        .and_hi (g_and_hi),
        .and_lo (g_and_lo),
        .or_hi  (g_or_hi),
        .or_lo  (g_or_lo),
        .not_hi (g_not_hi),
        .not_lo (g_not_lo)
    );

    dr_completion #(.N(NRES)) u_complete (
        .hi          ({g_and_hi, g_or_hi, g_not_hi}),
        .lo          ({g_and_lo, g_or_lo, g_not_lo}),
        .all_data    (res_all_data),
        .all_spacer  (res_all_spacer),
        .any_illegal (res_bad)
    );

    always_comb begin
        st_d = st_q;
        // R1: first register stage holds the sampled operands
        st_d.a_hi   = ca_hi;
        st_d.a_lo   = ca_lo;
        st_d.b_hi   = cb_hi;
        st_d.b_lo   = cb_lo;
        st_d.in_bad = bad_a | bad_b;
        // second stage holds results
        st_d.and_hi = g_and_hi;
        st_d.and_lo = g_and_lo;
        st_d.or_hi  = g_or_hi;
        st_d.or_lo  = g_or_lo;
        st_d.not_hi = g_not_hi;
        st_d.not_lo = g_not_lo;
        // R9: flag travels with the results of the offending sample
        st_d.err    = st_q.in_bad | res_bad;
        // R7, R8: completion with hysteresis
        if (res_all_data) begin
            st_d.done = 1'b1;
        end else if (res_all_spacer) begin
            st_d.done = 1'b0;
        end else begin
            st_d.done = st_q.done;
        end
    end

    // R10: everything clears to spacer on reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign and_hi = st_q.and_hi;
    assign and_lo = st_q.and_lo;
    assign or_hi  = st_q.or_hi;
    assign or_lo  = st_q.or_lo;
    assign not_hi = st_q.not_hi;
    assign not_lo = st_q.not_lo;
    assign done   = st_q.done;
    assign err    = st_q.err;

endmodule

// File: rtl/dual_rail_eval_chk.sv
module dual_rail_eval_chk #(
    parameter int W = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] a_hi,
    input logic [W-1:0] a_lo,
    input logic [W-1:0] b_hi,
    input logic [W-1:0] b_lo,
    input logic [W-1:0] and_hi,
    input logic [W-1:0] and_lo,
    input logic [W-1:0] or_hi,
    input logic [W-1:0] or_lo,
    input logic [W-1:0] not_hi,
    input logic [W-1:0] not_lo,
    input logic         done,
    input logic         err
);

    logic [1:0] cyc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc <= 2'd0;
        end else if (cyc != 2'd3) begin
            cyc <= cyc + 2'd1;
        end
    end

    // R5
    no_illegal_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((and_hi & and_lo) | (or_hi & or_lo) | (not_hi & not_lo)) == '0);

    // R4
    not_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 2'd3 && !err) |->
        (not_hi == $past(a_lo, 2) && not_lo == $past(a_hi, 2)));

    // R6
    bad_bit_spacer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 2'd3) |->
        (((not_hi | not_lo) & $past(a_hi & a_lo, 2)) == '0));

    // R9
    err_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 2'd3 && ($past(|(a_hi & a_lo), 2) || $past(|(b_hi & b_lo), 2)))
        |-> err);

    // R7
    done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc != 2'd0 && $rose(done)) |->
        ((and_hi ^ and_lo) == '1 && (or_hi ^ or_lo) == '1 && (not_hi ^ not_lo) == '1));

    // R8
    done_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc != 2'd0 && $fell(done)) |->
        ((and_hi | and_lo | or_hi | or_lo | not_hi | not_lo) == '0));

endmodule

bind dual_rail_eval dual_rail_eval_chk #(.W(W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .a_hi   (a_hi),
    .a_lo   (a_lo),
    .b_hi   (b_hi),
    .b_lo   (b_lo),
    .and_hi (and_hi),
    .and_lo (and_lo),
    .or_hi  (or_hi),
    .or_lo  (or_lo),
    .not_hi (not_hi),
    .not_lo (not_lo),
    .done   (done),
    .err    (err)
);

// File: tb/dual_rail_eval_bench.sv
`timescale 1ns/1ps
module dual_rail_eval_bench;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a_hi = '0, a_lo = '0, b_hi = '0, b_lo = '0;
    logic [W-1:0] and_hi, and_lo, or_hi, or_lo, not_hi, not_lo;
    logic         done, err;

    int total = 0;
    int bad = 0;

    // operands driven one and two negedges ago
    logic [W-1:0] p1_ah = '0, p1_al = '0, p1_bh = '0, p1_bl = '0;
    logic [W-1:0] p2_ah = '0, p2_al = '0, p2_bh = '0, p2_bl = '0;
    bit done_m = 1'b0;

    always #5 clk = ~clk;

    dual_rail_eval #(.W(W)) u_dual_rail_eval (
        .clk(clk), .rst_n(rst_n),
        .a_hi(a_hi), .a_lo(a_lo), .b_hi(b_hi), .b_lo(b_lo),
        .and_hi(and_hi), .and_lo(and_lo), .or_hi(or_hi), .or_lo(or_lo),
        .not_hi(not_hi), .not_lo(not_lo), .done(done), .err(err)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // 0 = logic 0, 1 = logic 1, 2 = spacer; illegal is read as spacer (R6)
    function automatic int decode(input bit h, input bit l);
        if (h && !l) return 1;
        if (!h && l) return 0;
        return 2;
    endfunction

    function automatic logic [1:0] encode(input int v);
        if (v == 0) return 2'b01;
        if (v == 1) return 2'b10;
        return 2'b00;
    endfunction

    task automatic compare_outputs();
        logic [W-1:0] eah, eal, eoh, eol, enh, enl;
        bit all_d, all_s, e_err;
        logic [1:0] c;
        all_d = 1'b1;
        all_s = 1'b1;
        e_err = 1'b0;
        for (int i = 0; i < W; i++) begin
            int va, vb, r;
            va = decode(p2_ah[i], p2_al[i]);
            vb = decode(p2_bh[i], p2_bl[i]);
            if ((p2_ah[i] && p2_al[i]) || (p2_bh[i] && p2_bl[i])) e_err = 1'b1;
            r = (va == 0 || vb == 0) ? 0 : ((va == 1 && vb == 1) ? 1 : 2);
            c = encode(r); eah[i] = c[1]; eal[i] = c[0];
            if (r == 2) all_d = 1'b0; else all_s = 1'b0;
            r = (va == 1 || vb == 1) ? 1 : ((va == 0 && vb == 0) ? 0 : 2);
            c = encode(r); eoh[i] = c[1]; eol[i] = c[0];
            if (r == 2) all_d = 1'b0; else all_s = 1'b0;
            r = (va == 2) ? 2 : 1 - va;
            c = encode(r); enh[i] = c[1]; enl[i] = c[0];
            if (r == 2) all_d = 1'b0; else all_s = 1'b0;
        end
        if (all_d) done_m = 1'b1;
        else if (all_s) done_m = 1'b0;
        check("R1 R2 and", {and_hi, and_lo}, {eah, eal});
        check("R1 R3 or", {or_hi, or_lo}, {eoh, eol});
        check("R4 R6 not", {not_hi, not_lo}, {enh, enl});
        check("R5 no 11 result", (and_hi & and_lo) | (or_hi & or_lo) | (not_hi & not_lo), '0);
        check("R7 R8 done", done, done_m);
        check("R9 err", err, e_err);
    endtask

    task automatic step(input logic [W-1:0] ah, input logic [W-1:0] al,
                        input logic [W-1:0] bh, input logic [W-1:0] bl);
        @(negedge clk);
        compare_outputs();
        p2_ah = p1_ah; p2_al = p1_al; p2_bh = p1_bh; p2_bl = p1_bl;
        p1_ah = ah;    p1_al = al;    p1_bh = bh;    p1_bl = bl;
        a_hi = ah; a_lo = al; b_hi = bh; b_lo = bl;
    endtask

    task automatic data_wave(input logic [W-1:0] a, input logic [W-1:0] b);
        step(a, ~a, b, ~b);
    endtask

    task automatic spacer_wave();
        step('0, '0, '0, '0);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #2000000;
        bad++;
        $display("FAIL watchdog expired, actual=hung expected=finished");
        finish_run();
    end

    initial begin
        // R10: reset state with data already applied at the inputs
        a_hi = 4'hA; a_lo = 4'h5; b_hi = 4'hF; b_lo = 4'h0;
        repeat (3) @(negedge clk);
        check("R10 reset results", {and_hi, and_lo, or_hi, or_lo, not_hi, not_lo}, '0);
        check("R10 reset done", done, 1'b0);
        check("R10 reset err", err, 1'b0);
        a_hi = '0; a_lo = '0; b_hi = '0; b_lo = '0;
        rst_n = 1'b1;
        spacer_wave();
        spacer_wave();

        // every operand pair, alternating data and spacer waves
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                data_wave(a[W-1:0], b[W-1:0]);
                spacer_wave();
            end
        end

        // R8: hysteresis through partial waves
        data_wave(4'h6, 4'h3);
        step(4'h6, 4'h8, 4'h3, 4'hC);          // bit 0 of A spacer
        step(4'h0, 4'h8, 4'h0, 4'h0);          // mostly spacer, AND bit3 early 0
        spacer_wave();
        step(4'h0, 4'hF, 4'h0, 4'h0);          // A all zeros, B spacer
        step(4'h0, 4'hF, 4'hF, 4'h0);          // full data
        step(4'h0, 4'hF, 4'h0, 4'h0);          // partial again
        spacer_wave();

        // R6, R9: illegal operand codes
        step(4'h4 | 4'h1, 4'h4 | 4'hA, 4'h3, 4'hC);
        spacer_wave();
        step(4'h9, 4'h6, 4'h1, 4'hF);
        step('1, '1, '1, '1);
        spacer_wave();
        data_wave(4'h5, 4'hA);

        // random codes per bit, including spacer and illegal
        for (int n = 0; n < 400; n++) begin
            logic [W-1:0] rah, ral, rbh, rbl;
            rah = $urandom; ral = $urandom; rbh = $urandom; rbl = $urandom;
            if (n % 3 == 0) begin
                ral = ~rah;
                rbl = ~rbh;
            end
            step(rah, ral, rbh, rbl);
        end

        repeat (3) spacer_wave();
        finish_run();
    end

endmodule